// File: doc/BRIEF.md
# Multi-Slot SD Host Wrapper Register Block

This block sits on a 32-bit register bus in front of up to two SD host slot controllers and owns a 4 KB address window. The lowest 256 bytes hold 64 shared words. Most of these words are plain storage. Some have a reset value. Four of them shadow each slot's capability and maximum-current settings, and those shadow values drive the slots continuously. One word, the last, holds the interrupt status.

Each active slot owns a 256-byte page above the shared page. Accesses to that page are passed straight through to the slot, with a one-hot select, and never touch the shared words. The per-slot interrupt lines are watched for level changes. Each change copies the new level into that slot's status bit and onto a single combined interrupt output.

A read returns data one cycle after its strobe, with a valid flag. A write takes effect on the clock edge that samples its strobe. The number of active slots is a parameter.

Top module: `sdw_wrapper`

## Requirements
- R1: After a synchronous reset, shared word 0 (byte 0x00) reads 0x00030000 and word 1 (byte 0x04) reads 0x00000005. Every other shared word reads 0, including the shadows and the status word at 0xFC. The combined interrupt output is 0.
- R2: Shared offsets that are neither shadows nor status (for example 0x08, 0xEC, 0xF0) act as plain storage. A read strobe produces `bus_rvalid` and `bus_rdata` on the following cycle. A write is visible to any later read.
- R3: `bus_size` encodes the access width as 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. Only value 2 is accepted. A rejected access writes nothing, selects no slot and produces no `bus_rvalid`.
- R4: Byte 0x10 holds slot 0's capability value and byte 0x18 its maximum-current value. Bytes 0x20 and 0x28 hold the same two values for slot 1. Each value reads back as written and appears on `slot_caps` / `slot_maxcur` (slot s in bits [32s+31:32s]) from the cycle after the write.
- R5: A word-sized access to byte (s+1)*0x100 + k, with s below NUM_SLOTS, raises only `slot_cs[s]` during the strobe cycle. It drives `slot_addr` = k, `slot_we` and `slot_wdata`. A read returns the slot's `slot_rdata[32s+31:32s]` as sampled in the strobe cycle. The shared words are unaffected.
- R6: A word-sized access at or above (NUM_SLOTS+1)*0x100 reads 0 with `bus_rvalid` high, and a write there changes nothing.
- R7: A rising or falling slot line n sets or clears status bit n (byte 0xFC, bit n) one clock after the change is sampled.
- R8: The combined interrupt output takes the new level of the slot line that changed most recently, even when another slot's status bit is still set.
- R9: When several slot lines change in the same cycle, the highest-numbered changing slot decides the combined output.
- R10: When a bus write to 0xFC and a slot line change land in the same cycle, each changed slot's bit takes the line level and every other bit takes the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access width code (2 = 4 bytes) |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after strobe |
| bus_rdata | output | 32 | Registered read data |
| slot_cs | output | NUM_SLOTS | One-hot slot page select |
| slot_we | output | 1 | Write flag for slot page access |
| slot_addr | output | 8 | Byte offset inside slot page |
| slot_wdata | output | 32 | Write data to slot |
| slot_rdata | input | 32*NUM_SLOTS | Read data from each slot |
| slot_irq | input | NUM_SLOTS | Per-slot interrupt level |
| slot_caps | output | 32*NUM_SLOTS | Capability value driven to each slot |
| slot_maxcur | output | 32*NUM_SLOTS | Maximum-current value driven to each slot |
| irq_out | output | 1 | Combined interrupt |

## Verification
Two events can land in the same cycle. The first case is a bus write to the status word together with a slot line edge. The second is two slot lines flipping at the same edge. The bench provokes the first by driving the status write and a rising slot 0 line on the same half-cycle. It then judges the read-back word bit by bit: the changed slot bit must follow its line, and every other bit must follow the written data. For the second case it swaps both lines at once in each direction and expects the combined output to follow slot 1 every time.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 12;
    localparam int PAGE_B        = 256;
    localparam int PAGE_LSB      = $clog2(PAGE_B);
    localparam int GWORDS        = PAGE_B / (DATA_W / 8);
    localparam int WIDX_W        = $clog2(GWORDS);
    localparam int PAGE_W        = ADDR_W - PAGE_LSB;
    localparam int MAX_SLOTS     = 2;
    localparam int SLOT_W        = $clog2(MAX_SLOTS);
    localparam int STATUS_IDX    = GWORDS - 1;
    localparam int SHADOW_STRIDE = 4;
    localparam int CUR_OFS       = 2;

    localparam logic [DATA_W-1:0] WORD0_RST = 32'h0003_0000;
    localparam logic [DATA_W-1:0] WORD1_RST = 32'h0000_0005;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_GLOBAL,
        TGT_CAP,
        TGT_CUR,
        TGT_STATUS,
        TGT_SLOT
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [SLOT_W-1:0] slot;
        logic [WIDX_W-1:0] widx;
    } dec_t;

    function automatic int cap_idx(int s);
        return SHADOW_STRIDE * (s + 1);
    endfunction

    function automatic int cur_idx(int s);
        return SHADOW_STRIDE * (s + 1) + CUR_OFS;
    endfunction

    // Word index that is not backed by the plain shared storage
    function automatic bit is_hole(int idx, int nslots);
        bit h = (idx == STATUS_IDX);
        for (int s = 0; s < MAX_SLOTS; s++) begin
            if (s < nslots && (idx == cap_idx(s) || idx == cur_idx(s))) h = 1'b1;
        end
        return h;
    endfunction

    function automatic word_t reset_value(int idx);
        case (idx)
            0:       return WORD0_RST;
            1:       return WORD1_RST;
            default: return '0;
        endcase
    endfunction

    function automatic dec_t decode(logic [ADDR_W-1:0] a, int nslots);
        dec_t              d;
        logic [PAGE_W-1:0] page;
        page   = a[ADDR_W-1 -: PAGE_W];
        d.tgt  = TGT_NONE;
        d.slot = '0;
        d.widx = a[PAGE_LSB-1 -: WIDX_W];
        if (page == '0) begin
            d.tgt = (int'(d.widx) == STATUS_IDX) ? TGT_STATUS : TGT_GLOBAL;
            for (int s = 0; s < MAX_SLOTS; s++) begin
                if (s < nslots && int'(d.widx) == cap_idx(s)) begin
                    d.tgt  = TGT_CAP;
                    d.slot = SLOT_W'(s);
                end
                if (s < nslots && int'(d.widx) == cur_idx(s)) begin
                    d.tgt  = TGT_CUR;
                    d.slot = SLOT_W'(s);
                end
            end
        end else begin
            for (int s = 0; s < MAX_SLOTS; s++) begin
                if (s < nslots && int'(page) == s + 1) begin
                    d.tgt  = TGT_SLOT;
                    d.slot = SLOT_W'(s);
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/sdw_decode.sv
module sdw_decode
    import sdw_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic              req,
    input  logic              wr,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic              acc_ok,
    output logic              rd_en,
    output logic              wr_en
);

    always_comb begin
        dec    = decode(addr, NUM_SLOTS);
        acc_ok = req && (acc_size_e'(size) == SZ_WORD);
        rd_en  = acc_ok && !wr;
        wr_en  = acc_ok && wr;
    end

endmodule

// File: rtl/sdw_gregs.sv
module sdw_gregs
    import sdw_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WIDX_W-1:0] widx,
    input  word_t             wdata,
    output word_t             rdata
);

    word_t mem [GWORDS];

    for (genvar g = 0; g < GWORDS; g++) begin : g_word
        if (is_hole(g, NUM_SLOTS)) begin : g_hole
            assign mem[g] = '0;
        end else begin : g_store
            word_t q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= reset_value(g);
                else if (we && widx == WIDX_W'(g))
                    q <= wdata;
            end
            assign mem[g] = q;
        end
    end

    assign rdata = mem[widx];

endmodule

// File: rtl/sdw_shadow.sv
module sdw_shadow
    import sdw_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SLOTS-1:0]       cap_we,
    input  logic [NUM_SLOTS-1:0]       cur_we,
    input  word_t                      wdata,
    output logic [NUM_SLOTS-1:0][31:0] caps,
    output logic [NUM_SLOTS-1:0][31:0] curs
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                caps[s] <= '0;
                curs[s] <= '0;
            end else begin
                if (cap_we[s]) caps[s] <= wdata;
                if (cur_we[s]) curs[s] <= wdata;
            end
        end

        p_cap_update_r4: assert property (@(posedge clk) disable iff (rst)
            cap_we[s] |=> caps[s] == $past(wdata));
        p_cur_update_r4: assert property (@(posedge clk) disable iff (rst)
            cur_we[s] |=> curs[s] == $past(wdata));
    end

endmodule

// File: rtl/sdw_irq.sv
module sdw_irq
    import sdw_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] line,
    input  logic                 st_we,
    input  word_t                st_wdata,
    output word_t                status,
    output logic                 irq_out
);

    logic [NUM_SLOTS-1:0] line_q;
    logic [NUM_SLOTS-1:0] chg;
    word_t                status_d;
    logic                 out_d;

    assign chg = line ^ line_q;

    always_comb begin
        status_d = st_we ? st_wdata : status;
        out_d    = irq_out;
        // ascending order: a higher changing slot overrides a lower one
        for (int n = 0; n < NUM_SLOTS; n++) begin
            if (chg[n]) begin
                status_d[n] = line[n];
                out_d       = line[n];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= '0;
            status  <= '0;
            irq_out <= 1'b0;
        end else begin
            line_q  <= line;
            status  <= status_d;
            irq_out <= out_d;
        end
    end

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_chk
        p_rise_sets_r7: assert property (@(posedge clk) disable iff (rst)
            $rose(line[n]) |=> status[n]);
        p_fall_clears_r7: assert property (@(posedge clk) disable iff (rst)
            $fell(line[n]) |=> !status[n]);
    end

    p_top_rise_wins_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(line[NUM_SLOTS-1]) |=> irq_out);
    p_top_fall_wins_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(line[NUM_SLOTS-1]) |=> !irq_out);

endmodule

// File: rtl/sdw_wrapper.sv
module sdw_wrapper
    import sdw_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_req,
    input  logic                        bus_wr,
    input  logic [1:0]                  bus_size,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic                        bus_rvalid,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic [NUM_SLOTS-1:0]        slot_cs,
    output logic                        slot_we,
    output logic [PAGE_LSB-1:0]         slot_addr,
    output logic [DATA_W-1:0]           slot_wdata,
    input  logic [NUM_SLOTS*DATA_W-1:0] slot_rdata,
    input  logic [NUM_SLOTS-1:0]        slot_irq,
    output logic [NUM_SLOTS*DATA_W-1:0] slot_caps,
    output logic [NUM_SLOTS*DATA_W-1:0] slot_maxcur,
    output logic                        irq_out
);

    localparam int OOR_BASE = (NUM_SLOTS + 1) * PAGE_B;

    dec_t  dec;
    logic  acc_ok, rd_en, wr_en;
    word_t g_rdata, status, rd_mux;
    logic  g_we, st_we;
    logic [NUM_SLOTS-1:0]        cap_we, cur_we;
    logic [NUM_SLOTS-1:0][31:0]  caps_w, curs_w, srd_w;

    sdw_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
        .req    (bus_req),
        .wr     (bus_wr),
        .size   (bus_size),
        .addr   (bus_addr),
        .dec    (dec),
        .acc_ok (acc_ok),
        .rd_en  (rd_en),
        .wr_en  (wr_en)
    );

    assign g_we  = wr_en && dec.tgt == TGT_GLOBAL;
    assign st_we = wr_en && dec.tgt == TGT_STATUS;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sel
        assign cap_we[s]  = wr_en && dec.tgt == TGT_CAP && dec.slot == SLOT_W'(s);
        assign cur_we[s]  = wr_en && dec.tgt == TGT_CUR && dec.slot == SLOT_W'(s);
        assign slot_cs[s] = acc_ok && dec.tgt == TGT_SLOT && dec.slot == SLOT_W'(s);
    end

    assign slot_we    = wr_en && dec.tgt == TGT_SLOT;
    assign slot_addr  = bus_addr[PAGE_LSB-1:0];
    assign slot_wdata = bus_wdata;
    assign srd_w      = slot_rdata;

    sdw_gregs #(.NUM_SLOTS(NUM_SLOTS)) u_gregs (
        .clk   (clk),
        .rst   (rst),
        .we    (g_we),
        .widx  (dec.widx),
        .wdata (bus_wdata),
        .rdata (g_rdata)
    );

    sdw_shadow #(.NUM_SLOTS(NUM_SLOTS)) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .cap_we (cap_we),
        .cur_we (cur_we),
        .wdata  (bus_wdata),
        .caps   (caps_w),
        .curs   (curs_w)
    );

    assign slot_caps   = caps_w;
    assign slot_maxcur = curs_w;

    sdw_irq #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .line     (slot_irq),
        .st_we    (st_we),
        .st_wdata (bus_wdata),
        .status   (status),
        .irq_out  (irq_out)
    );

    always_comb begin
        case (dec.tgt)
            TGT_GLOBAL: rd_mux = g_rdata;
            TGT_CAP:    rd_mux = caps_w[dec.slot];
            TGT_CUR:    rd_mux = curs_w[dec.slot];
            TGT_STATUS: rd_mux = status;
            TGT_SLOT:   rd_mux = srd_w[dec.slot];
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_en;
            if (rd_en) bus_rdata <= rd_mux;
        end
    end

    p_word_read_valid_r2: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_wr && bus_size == 2'd2 |=> bus_rvalid);
    p_bad_size_no_valid_r3: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_wr && bus_size != 2'd2 |=> !bus_rvalid);
    p_bad_size_no_select_r3: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_size != 2'd2 |-> slot_cs == '0);
    p_select_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_cs));
    p_out_of_range_zero_r6: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_wr && bus_size == 2'd2 && int'(bus_addr) >= OOR_BASE
        |=> bus_rdata == '0);

endmodule

// File: tb/tb_sdw_wrapper.sv
module tb_sdw_wrapper;
    localparam int NS = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_req = 1'b0, bus_wr = 1'b0;
    logic [1:0]      bus_size = 2'd2;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_rvalid;
    logic [31:0]     bus_rdata;
    logic [NS-1:0]   slot_cs;
    logic            slot_we;
    logic [7:0]      slot_addr;
    logic [31:0]     slot_wdata;
    logic [NS*32-1:0] slot_rdata;
    logic [NS-1:0]   slot_irq = '0;
    logic [NS*32-1:0] slot_caps, slot_maxcur;
    logic            irq_out;

    int checks = 0;
    int failures = 0;
    logic [NS-1:0] cs_seen;
    logic [39:0]   last_wr [NS];

    always #2.5 clk = ~clk;

    sdw_wrapper #(.NUM_SLOTS(NS)) dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .slot_cs(slot_cs),
        .slot_we(slot_we), .slot_addr(slot_addr), .slot_wdata(slot_wdata),
        .slot_rdata(slot_rdata), .slot_irq(slot_irq), .slot_caps(slot_caps),
        .slot_maxcur(slot_maxcur), .irq_out(irq_out)
    );

    // slot model: read data encodes slot number and offset
    always_comb begin
        for (int s = 0; s < NS; s++)
            slot_rdata[s*32 +: 32] = {8'h51, 8'(s), 8'h00, slot_addr};
    end

    always @(posedge clk) begin
        for (int s = 0; s < NS; s++)
            if (slot_we && slot_cs[s]) last_wr[s] <= {slot_addr, slot_wdata};
    end

    function automatic logic [31:0] pat(int i);
        return 32'hA500_0000 | (32'(i) << 8) | (32'hFF ^ 32'(i));
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d, logic [1:0] sz = 2'd2);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        #1 cs_seen = slot_cs;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0; bus_size = 2'd2;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] d, output logic rv,
                            input logic [1:0] sz = 2'd2);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        #1 cs_seen = slot_cs;
        @(negedge clk);
        bus_req = 1'b0; bus_size = 2'd2;
        rv = bus_rvalid; d = bus_rdata;
    endtask

    task automatic set_lines(logic [NS-1:0] v);
        @(negedge clk);
        slot_irq = v;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog act=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic rv;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values of all shared words
        chk("R1 irq_out", 64'(irq_out), 64'd0);
        for (int i = 0; i < 64; i++) begin
            bus_read(12'(i*4), d, rv);
            exp = (i == 0) ? 32'h0003_0000 : (i == 1) ? 32'h5 : 32'h0;
            chk($sformatf("R1 word %0d", i), 64'(d), 64'(exp));
        end
        chk("R1 caps", 64'(slot_caps), 64'd0);

        // R2/R4: sweep write then read every shared word
        for (int i = 0; i < 64; i++) bus_write(12'(i*4), pat(i));
        for (int i = 0; i < 64; i++) begin
            bus_read(12'(i*4), d, rv);
            chk($sformatf("R2 rvalid %0d", i), 64'(rv), 64'd1);
            chk($sformatf("R2/R4 word %0d", i), 64'(d), 64'(pat(i)));
        end
        chk("R4 slot0 caps", 64'(slot_caps[31:0]), 64'(pat(4)));
        chk("R4 slot0 maxcur", 64'(slot_maxcur[31:0]), 64'(pat(6)));
        chk("R4 slot1 caps", 64'(slot_caps[63:32]), 64'(pat(8)));
        chk("R4 slot1 maxcur", 64'(slot_maxcur[63:32]), 64'(pat(10)));

        // R3: rejected sizes
        for (int sz = 0; sz < 4; sz++) begin
            if (sz == 2) continue;
            bus_write(12'h008, 32'hDEAD_0000 | 32'(sz), 2'(sz));
            bus_read(12'h008, d, rv, 2'(sz));
            chk($sformatf("R3 no rvalid sz%0d", sz), 64'(rv), 64'd0);
            bus_write(12'h110, 32'h1234, 2'(sz));
            chk($sformatf("R3 no select sz%0d", sz), 64'(cs_seen), 64'd0);
            bus_read(12'h008, d, rv);
            chk($sformatf("R3 unchanged sz%0d", sz), 64'(d), 64'(pat(2)));
        end

        // R5: slot pages
        bus_read(12'h124, d, rv);
        chk("R5 slot0 select", 64'(cs_seen), 64'd1);
        chk("R5 slot0 read", 64'(d), 64'h5100_0024);
        bus_read(12'h2F0, d, rv);
        chk("R5 slot1 select", 64'(cs_seen), 64'd2);
        chk("R5 slot1 read", 64'(d), 64'h5101_00F0);
        bus_write(12'h104, 32'hCAFE_F00D);
        chk("R5 slot0 write", 64'(last_wr[0]), 64'h04_CAFE_F00D);
        bus_write(12'h2FC, 32'h0BAD_BEEF);
        chk("R5 slot1 write", 64'(last_wr[1]), 64'hFC_0BAD_BEEF);
        bus_read(12'h004, d, rv);
        chk("R5 shared untouched", 64'(d), 64'(pat(1)));

        // R6: out-of-range pages
        for (int pg = 3; pg < 16; pg++) begin
            bus_write(12'(pg*256 + 8), 32'hFFFF_FFFF);
            bus_read(12'(pg*256 + 8), d, rv);
            chk($sformatf("R6 page %0d", pg), {31'd0, rv, d}, 64'h1_0000_0000);
        end
        bus_read(12'h008, d, rv);
        chk("R6 shared untouched", 64'(d), 64'(pat(2)));

        // R7/R8/R9: interrupt lines
        bus_write(12'h0FC, 32'h0);
        set_lines(2'b01);
        chk("R8 out after slot0 rise", 64'(irq_out), 64'd1);
        bus_read(12'h0FC, d, rv);
        chk("R7 status 01", 64'(d), 64'h1);
        set_lines(2'b11);
        bus_read(12'h0FC, d, rv);
        chk("R7 status 11", 64'(d), 64'h3);
        set_lines(2'b10);
        chk("R8 out follows slot0 fall", 64'(irq_out), 64'd0);
        bus_read(12'h0FC, d, rv);
        chk("R7 status 10", 64'(d), 64'h2);
        set_lines(2'b01);
        chk("R9 both change, slot1 falls", 64'(irq_out), 64'd0);
        bus_read(12'h0FC, d, rv);
        chk("R9 status 01", 64'(d), 64'h1);
        set_lines(2'b10);
        chk("R9 both change, slot1 rises", 64'(irq_out), 64'd1);

        // R10: status write and slot0 rise in the same cycle
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 12'h0FC; bus_wdata = 32'hA5A5_A5A4;
        slot_irq = 2'b11;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
        chk("R8 out after slot0 rise", 64'(irq_out), 64'd1);
        bus_read(12'h0FC, d, rv);
        chk("R10 merged status", 64'(d), 64'hA5A5_A5A5);
        set_lines(2'b00);
        chk("R9 both fall", 64'(irq_out), 64'd0);
        bus_read(12'h0FC, d, rv);
        chk("R7 status cleared", 64'(d), 64'hA5A5_A5A4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule